// File: doc/BRIEF.md
# Pipelined RAM-Emulated Ternary Match Unit

This block answers a ternary lookup without any ternary cell array. It holds `ENTRIES` ternary entries, each `KEY_W` bits wide, spread over `SEGS` small RAMs. Every RAM has `2^SEG_W` words of `ENTRIES` bits. The search key is cut into `SEGS` slices of `SEG_W` bits. Slice i addresses RAM i, and the word read back lists the entries that would accept that slice. The AND of all the words gives the per-entry match vector. A priority encoder reduces that vector to the lowest matching entry.

The RAMs are spread over `STAGES` pipeline stages, and each stage narrows the vector it receives. An output register stage follows them, so a new key can enter on every cycle. Units are meant to be chained. A unit takes the preceding unit's match flag and identifier alongside the key, delays them with it, and lets an upstream hit win over its own. An external update engine fills the RAMs through a single write port. While that engine raises its busy line, the unit withholds its result-valid flag.

Top module: `tern_match_unit`

## Requirements
- R1: Entry j matches a key exactly when, for every segment i, bit j of the word at address `key[i*SEG_W +: SEG_W]` in RAM i is 1. The unit's match flag reports this intersection.
- R2: When several entries match, the reported entry is the one with the lowest index.
- R3: `match_out` is 1 exactly when the upstream flag or any local entry matched. When neither matched, `id_out` is 0.
- R4: When `match_in` was 1 with a key, the result for that key has `match_out` = 1 and `id_out` equal to that key's `id_in`, whatever the local entries hold.
- R5: A local hit on entry j, with no upstream hit, gives `id_out` = `BASE_ID` + j.
- R6: Results, including `key_out` (a copy of the key), appear `STAGES`+1 cycles after the key is presented. A new key is accepted on every cycle.
- R7: `key_vld_out` equals `key_vld_in` from `STAGES`+1 cycles earlier. It is forced to 0 on the cycle after any cycle in which `upd_busy` is 1.
- R8: Reset clears every RAM word, so no entry matches, and it drives `key_vld_out`, `match_out` and `id_out` to 0.
- R9: With `upd_we` = 1, `upd_data` is written at address `upd_addr` of the RAM selected by `upd_sel` (0 to `SEGS`-1, where RAM i serves key bits `[i*SEG_W +: SEG_W]`). A read at the same address in the same cycle returns the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_in | input | KEY_W | Search key |
| key_vld_in | input | 1 | Key qualifier |
| match_in | input | 1 | Upstream unit found a match for this key |
| id_in | input | ID_W | Upstream matching identifier |
| upd_busy | input | 1 | Update engine active; blanks the result-valid flag |
| upd_we | input | 1 | RAM write strobe |
| upd_sel | input | SEL_W | Which segment RAM to write |
| upd_addr | input | SEG_W | Word address in the selected RAM |
| upd_data | input | ENTRIES | Per-entry match bits to store |
| key_out | output | KEY_W | Delayed key for the next unit |
| key_vld_out | output | 1 | Result valid |
| match_out | output | 1 | Any match, upstream or local |
| id_out | output | ID_W | Winning identifier |

## Verification
Several properties are checked on every cycle:
- the encoder's chosen index is set in the final vector, and no lower bit is set;
- any non-zero vector raises the local hit;
- a stage never adds bits that were absent from the vector it received;
- an idle result carries identifier 0, and a local identifier lies in the unit's own window;
- an upstream hit is passed through;
- busy blanks the valid flag.

Only the bench's scenarios show whether the lookups themselves are right. Those scenarios compare every cycle against a model built from ternary data and masks, covering overlapping entries, the first and last entry, an empty table after reset, upstream overrides and reloads made under busy.

// File: rtl/tern_match_pkg.sv
package tern_match_pkg;
    typedef enum logic [1:0] {
        SRC_NONE     = 2'd0,
        SRC_LOCAL    = 2'd1,
        SRC_UPSTREAM = 2'd2
    } id_src_t;
endpackage

// File: rtl/tern_seg_ram.sv
// One segment RAM: registered read, single write port, read-first on collision.
module tern_seg_ram #(
    parameter int AW = 5,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
            rdata <= '0;
        end else begin
            rdata <= mem[raddr];
            if (we) mem[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/tern_prio_enc.sv
// Lowest set bit wins.
module tern_prio_enc #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic [N-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tern_match_stage.sv
// One pipeline stage: N_RAM segment RAMs read by the incoming key, their
// words ANDed with the vector carried from the previous stage.
module tern_match_stage #(
    parameter int SEG_W     = 5,
    parameter int N_RAM     = 2,
    parameter int FIRST_SEG = 0,
    parameter int ENTRIES   = 64,
    parameter int KEY_W     = 20,
    parameter int ID_W      = 16,
    parameter int SEL_W     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [KEY_W-1:0]   in_key,
    input  logic [ENTRIES-1:0] in_vec,
    input  logic               in_vld,
    input  logic               in_up_hit,
    input  logic [ID_W-1:0]    in_up_id,
    input  logic               upd_we,
    input  logic [SEL_W-1:0]   upd_sel,
    input  logic [SEG_W-1:0]   upd_addr,
    input  logic [ENTRIES-1:0] upd_data,
    output logic [KEY_W-1:0]   out_key,
    output logic [ENTRIES-1:0] out_vec,
    output logic               out_vld,
    output logic               out_up_hit,
    output logic [ID_W-1:0]    out_up_id
);
    logic [ENTRIES-1:0] rd [N_RAM];
    logic [ENTRIES-1:0] vec_q;

    for (genvar r = 0; r < N_RAM; r++) begin : g_ram
        localparam int G = FIRST_SEG + r;
        logic we_r;
        assign we_r = upd_we && (upd_sel == SEL_W'(G));
        tern_seg_ram #(.AW(SEG_W), .DW(ENTRIES)) u_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_r),
            .waddr (upd_addr),
            .wdata (upd_data),
            .raddr (in_key[G*SEG_W +: SEG_W]),
            .rdata (rd[r])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_key    <= '0;
            vec_q      <= '0;
            out_vld    <= 1'b0;
            out_up_hit <= 1'b0;
            out_up_id  <= '0;
        end else begin
            out_key    <= in_key;
            vec_q      <= in_vec;
            out_vld    <= in_vld;
            out_up_hit <= in_up_hit;
            out_up_id  <= in_up_id;
        end
    end

    always_comb begin
        out_vec = vec_q;
        for (int r = 0; r < N_RAM; r++) out_vec = out_vec & rd[r];
    end

    // R1: a stage can only clear candidates, never add them
    assert_vec_narrows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((out_vec & ~$past(in_vec)) == '0));
endmodule

// File: rtl/tern_match_unit.sv
module tern_match_unit #(
    parameter int SEG_W   = 5,
    parameter int SEGS    = 4,
    parameter int ENTRIES = 64,
    parameter int STAGES  = 2,
    parameter int ID_W    = 16,
    parameter int BASE_ID = 0,
    localparam int KEY_W  = SEGS * SEG_W,
    localparam int SEL_W  = (SEGS > 1) ? $clog2(SEGS) : 1,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [KEY_W-1:0]   key_in,
    input  logic               key_vld_in,
    input  logic               match_in,
    input  logic [ID_W-1:0]    id_in,
    input  logic               upd_busy,
    input  logic               upd_we,
    input  logic [SEL_W-1:0]   upd_sel,
    input  logic [SEG_W-1:0]   upd_addr,
    input  logic [ENTRIES-1:0] upd_data,
    output logic [KEY_W-1:0]   key_out,
    output logic               key_vld_out,
    output logic               match_out,
    output logic [ID_W-1:0]    id_out
);
    import tern_match_pkg::*;

    localparam int SEGS_PER_STAGE = SEGS / STAGES;

    logic [KEY_W-1:0]   ln_key [STAGES+1];
    logic [ENTRIES-1:0] ln_vec [STAGES+1];
    logic               ln_vld [STAGES+1];
    logic               ln_hit [STAGES+1];
    logic [ID_W-1:0]    ln_id  [STAGES+1];

    assign ln_key[0] = key_in;
    assign ln_vec[0] = '1;
    assign ln_vld[0] = key_vld_in;
    assign ln_hit[0] = match_in;
    assign ln_id[0]  = id_in;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        tern_match_stage #(
            .SEG_W     (SEG_W),
            .N_RAM     (SEGS_PER_STAGE),
            .FIRST_SEG (s * SEGS_PER_STAGE),
            .ENTRIES   (ENTRIES),
            .KEY_W     (KEY_W),
            .ID_W      (ID_W),
            .SEL_W     (SEL_W)
        ) u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_key     (ln_key[s]),
            .in_vec     (ln_vec[s]),
            .in_vld     (ln_vld[s]),
            .in_up_hit  (ln_hit[s]),
            .in_up_id   (ln_id[s]),
            .upd_we     (upd_we),
            .upd_sel    (upd_sel),
            .upd_addr   (upd_addr),
            .upd_data   (upd_data),
            .out_key    (ln_key[s+1]),
            .out_vec    (ln_vec[s+1]),
            .out_vld    (ln_vld[s+1]),
            .out_up_hit (ln_hit[s+1]),
            .out_up_id  (ln_id[s+1])
        );
    end

    logic             loc_hit;
    logic [IDX_W-1:0] loc_idx;

    tern_prio_enc #(.N(ENTRIES), .IW(IDX_W)) u_enc (
        .vec (ln_vec[STAGES]),
        .hit (loc_hit),
        .idx (loc_idx)
    );

    id_src_t src_d, src_q;

    always_comb begin
        if (ln_hit[STAGES])  src_d = SRC_UPSTREAM;
        else if (loc_hit)    src_d = SRC_LOCAL;
        else                 src_d = SRC_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= SRC_NONE;
        else        src_q <= src_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_out     <= '0;
            key_vld_out <= 1'b0;
            match_out   <= 1'b0;
            id_out      <= '0;
        end else begin
            key_out     <= ln_key[STAGES];
            key_vld_out <= ln_vld[STAGES] && !upd_busy;
            unique case (src_d)
                SRC_UPSTREAM: begin
                    match_out <= 1'b1;
                    id_out    <= ln_id[STAGES];
                end
                SRC_LOCAL: begin
                    match_out <= 1'b1;
                    id_out    <= ID_W'(BASE_ID) + ID_W'(loc_idx);
                end
                default: begin
                    match_out <= 1'b0;
                    id_out    <= '0;
                end
            endcase
        end
    end

    assert_enc_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        loc_hit |-> ln_vec[STAGES][loc_idx]);

    assert_enc_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        loc_hit |-> ((ln_vec[STAGES] & ((ENTRIES'(1) << loc_idx) - ENTRIES'(1))) == '0));

    assert_enc_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_vec[STAGES] != '0) |-> loc_hit);

    assert_quiet_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !match_out |-> (id_out == '0));

    assert_local_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == SRC_LOCAL) |-> (int'(id_out) >= BASE_ID && int'(id_out) < BASE_ID + ENTRIES));

    assert_upstream_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ln_hit[STAGES] |=> (match_out && id_out == $past(ln_id[STAGES])));

    assert_busy_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_busy |=> !key_vld_out);
endmodule

// File: tb/tern_match_unit_bench.sv
module tern_match_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SEG_W   = 5;
    localparam int SEGS    = 4;
    localparam int ENTRIES = 64;
    localparam int STAGES  = 2;
    localparam int ID_W    = 16;
    localparam int BASE    = 192;
    localparam int KEY_W   = SEGS * SEG_W;
    localparam int LAT     = STAGES + 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [KEY_W-1:0]   key_in = '0;
    logic               key_vld_in = 1'b0;
    logic               match_in = 1'b0;
    logic [ID_W-1:0]    id_in = '0;
    logic               upd_busy = 1'b0;
    logic               upd_we = 1'b0;
    logic [1:0]         upd_sel = '0;
    logic [SEG_W-1:0]   upd_addr = '0;
    logic [ENTRIES-1:0] upd_data = '0;
    logic [KEY_W-1:0]   key_out;
    logic               key_vld_out;
    logic               match_out;
    logic [ID_W-1:0]    id_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    tern_match_unit #(
        .SEG_W(SEG_W), .SEGS(SEGS), .ENTRIES(ENTRIES),
        .STAGES(STAGES), .ID_W(ID_W), .BASE_ID(BASE)
    ) u_tern_match_unit (
        .clk, .rst_n, .key_in, .key_vld_in, .match_in, .id_in,
        .upd_busy, .upd_we, .upd_sel, .upd_addr, .upd_data,
        .key_out, .key_vld_out, .match_out, .id_out
    );

    typedef struct {
        logic             vld;
        logic [KEY_W-1:0] key;
        logic             mt;
        logic [ID_W-1:0]  id;
        int               kind; // 0 none, 1 local, 2 upstream
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    logic busy_last = 1'b0;

    // ternary table held as data/mask per entry
    logic [KEY_W-1:0] ent_data [ENTRIES];
    logic [KEY_W-1:0] ent_mask [ENTRIES];
    logic             ent_used [ENTRIES];

    // staged stimulus
    logic [KEY_W-1:0]   nx_key = '0;
    logic               nx_vld = 1'b0;
    logic               nx_mi = 1'b0;
    logic [ID_W-1:0]    nx_id = '0;
    logic               nx_busy = 1'b0;
    logic               nx_we = 1'b0;
    logic [1:0]         nx_sel = '0;
    logic [SEG_W-1:0]   nx_addr = '0;
    logic [ENTRIES-1:0] nx_data = '0;

    task automatic fail(string req, logic [31:0] act, logic [31:0] expv);
        errors++;
        $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    endtask

    task automatic check_out();
        exp_t e;
        logic ev;
        if (exp_q.size() == LAT) begin
            e = exp_q.pop_front();
            ev = e.vld && !busy_last;
            checks++;
            if (key_vld_out !== ev) fail("R7 valid", 32'(key_vld_out), 32'(ev));
            if (ev) begin
                checks++;
                if (key_out !== e.key) fail("R6 key_out", 32'(key_out), 32'(e.key));
                checks++;
                if (match_out !== e.mt)
                    fail(e.kind == 2 ? "R4 match" : (e.kind == 1 ? "R1/R9 match" : "R3 match"),
                         32'(match_out), 32'(e.mt));
                checks++;
                if (id_out !== e.id)
                    fail(e.kind == 2 ? "R4 id" : (e.kind == 1 ? "R2/R5 id" : "R3 id"),
                         32'(id_out), 32'(e.id));
            end
        end
    endtask

    function automatic exp_t model(logic [KEY_W-1:0] k, logic v, logic mi, logic [ID_W-1:0] idi);
        exp_t e;
        int win = -1;
        for (int j = ENTRIES - 1; j >= 0; j--)
            if (ent_used[j] && (((k ^ ent_data[j]) & ent_mask[j]) == '0)) win = j;
        e.vld = v;
        e.key = k;
        if (mi) begin
            e.mt = 1'b1; e.id = idi; e.kind = 2;
        end else if (win >= 0) begin
            e.mt = 1'b1; e.id = ID_W'(BASE + win); e.kind = 1;
        end else begin
            e.mt = 1'b0; e.id = '0; e.kind = 0;
        end
        return e;
    endfunction

    task automatic step();
        @(negedge clk);
        check_out();
        key_in     = nx_key;
        key_vld_in = nx_vld;
        match_in   = nx_mi;
        id_in      = nx_id;
        upd_busy   = nx_busy;
        upd_we     = nx_we;
        upd_sel    = nx_sel;
        upd_addr   = nx_addr;
        upd_data   = nx_data;
        busy_last  = nx_busy;
        exp_q.push_back(model(nx_key, nx_vld, nx_mi, nx_id));
    endtask

    task automatic search(logic [KEY_W-1:0] k, logic v, logic mi, logic [ID_W-1:0] idi);
        nx_key = k; nx_vld = v; nx_mi = mi; nx_id = idi;
        step();
    endtask

    function automatic void clear_table();
        for (int j = 0; j < ENTRIES; j++) begin
            ent_used[j] = 1'b0; ent_data[j] = '0; ent_mask[j] = '0;
        end
    endfunction

    // R9: rewrite every RAM word from the ternary table, under busy,
    // with random valid keys riding along (they must come out blanked, R7)
    task automatic load_table();
        nx_busy = 1'b1;
        for (int i = 0; i < SEGS; i++) begin
            for (int a = 0; a < (1 << SEG_W); a++) begin
                logic [ENTRIES-1:0] v = '0;
                for (int j = 0; j < ENTRIES; j++) begin
                    logic [SEG_W-1:0] sd = ent_data[j][i*SEG_W +: SEG_W];
                    logic [SEG_W-1:0] sm = ent_mask[j][i*SEG_W +: SEG_W];
                    if (ent_used[j] && (((SEG_W'(a) ^ sd) & sm) == '0)) v[j] = 1'b1;
                end
                nx_we = 1'b1; nx_sel = 2'(i); nx_addr = SEG_W'(a); nx_data = v;
                search(KEY_W'($urandom), 1'b1, 1'b0, '0);
            end
        end
        nx_we = 1'b0;
        for (int c = 0; c <= LAT; c++) search(KEY_W'($urandom), 1'b1, 1'b0, '0);
        nx_busy = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_table();
        repeat (3) @(negedge clk);
        // R8: outputs after reset
        checks++; if (key_vld_out !== 1'b0) fail("R8 valid", 32'(key_vld_out), 0);
        checks++; if (match_out !== 1'b0) fail("R8 match", 32'(match_out), 0);
        checks++; if (id_out !== '0) fail("R8 id", 32'(id_out), 0);
        rst_n = 1'b1;

        // R8: empty RAMs, nothing matches; back-to-back keys (R6)
        for (int c = 0; c < 12; c++) search(KEY_W'($urandom), 1'b1, 1'b0, '0);

        // table A: overlapping entries for priority (R2), catch-all, exact key
        ent_used[2]  = 1; ent_data[2]  = 20'hAB000; ent_mask[2]  = 20'hFF000;
        ent_used[5]  = 1; ent_data[5]  = 20'h12345; ent_mask[5]  = 20'hFFFFF;
        ent_used[9]  = 1; ent_data[9]  = 20'h00000; ent_mask[9]  = 20'h00000;
        ent_used[40] = 1; ent_data[40] = 20'h00C00; ent_mask[40] = 20'h00F00;
        load_table();
        for (int c = 0; c < 40; c++) begin
            logic [KEY_W-1:0] k;
            case (c % 4)
                0: k = 20'h12345;
                1: k = {8'hAB, 12'($urandom)};
                2: k = {8'($urandom), 4'hC, 8'($urandom)};
                default: k = KEY_W'($urandom);
            endcase
            search(k, 1'($urandom), 1'b0, '0);
        end

        // R4: upstream hits override the local result
        for (int c = 0; c < 16; c++)
            search(c[0] ? 20'h12345 : KEY_W'($urandom), 1'b1, c[1], ID_W'($urandom));

        // R7: busy without writes blanks valid
        nx_busy = 1'b1;
        for (int c = 0; c < 5; c++) search(20'hAB001, 1'b1, 1'b0, '0);
        nx_busy = 1'b0;
        for (int c = 0; c < 5; c++) search(20'hAB001, 1'b1, 1'b0, '0);

        // table B: first and last entries (R5 base offset at both ends)
        clear_table();
        ent_used[63] = 1; ent_data[63] = 20'h0F0F0; ent_mask[63] = 20'h0FFF0;
        ent_used[0]  = 1; ent_data[0]  = 20'hFFFFF; ent_mask[0]  = 20'h80001;
        load_table();
        for (int c = 0; c < 8; c++) begin
            search(20'h0F0F0, 1'b1, 1'b0, '0);  // entry 63
            search(20'h8F0F1, 1'b1, 1'b0, '0);  // both; entry 0 wins
            search(20'h00000, 1'b1, 1'b0, '0);  // none
            search(20'h80001, 1'b1, 1'b0, '0);  // entry 0
        end
        for (int c = 0; c < LAT + 1; c++) search('0, 1'b0, 1'b0, '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule